// File: doc/BRIEF.md
# Virtual Address Range and Tag Checker

This block looks at a 64-bit virtual address before any table walk begins. It decides whether the address lies inside the region that the lower translation table covers. It also reports the level at which the walk has to start, the output-address width that the physical size code selects, and whether the access skips tag checking. The control inputs are the effective values of the translation control fields: the region size offset, the granule, top-byte masking with its data-only qualifier, tag-nibble masking, the 52-bit wide mode, the unchecked-tag enable and the physical size code.

The region covers 2^(64 − size offset) bytes. Every address bit from position 64 − size offset upward has to be zero once the masking modes have removed the bits they exclude. Some size offsets are never legal: those below the minimum that the wide mode sets, and those above 48. Such an offset raises a level-0 fault whatever the address. The results are registered, and each valid request produces one result exactly one cycle later.

Top module: `va_range_check`

## Requirements
- R1: A request with `in_valid` high produces `out_valid` high on the following clock edge. `out_valid` is never high without a request one cycle earlier. After reset every output reads zero.
- R2: `l0_fault` is set when any address bit at position 64 − `size_off` or above is 1, after the masking of R3 and R4 has been applied.
- R3: With `top_ign` = 1, bits 63:56 take no part in the range check. `acc_kind` is encoded as 00 for an instruction fetch, 01 for a data access, 10 for a maintenance or address-translation operation, and 11, which counts as data. When `top_ign_data_only` = 1, the masking applies to every kind except 00.
- R4: With `tag_nib_ext` = 1, bits 59:56 are read as 0000 for the range check.
- R5: `l0_fault` is set for every address when `size_off` is below 16 with `wide_mode` = 0, below 12 with `wide_mode` = 1, or above 48.
- R6: `start_lvl` is a signed 3-bit value. It equals 4 − L, where L = max(1, ceil((64 − size_off − P)/S)). The granule code picks P and S: 00 gives 4KB with P = 12, S = 9; 10 gives 16KB with P = 14, S = 11; 01 gives 64KB with P = 16, S = 13; 11 is treated as 4KB. For example, 4KB with size offset 12 to 15 gives −1 (3'b111), and 16KB with size offset 16 gives 0. On a fault, `start_lvl` is 0.
- R7: `oa_bits` decodes `pa_code` 000 to 111 as 32, 36, 40, 42, 44, 48, 52 and 56.
- R8: `tag_unchecked` is 1 exactly when `unchk_en` = 1 and raw address bits 59:56 are 0000, whatever the masking modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request present |
| vaddr | input | 64 | Virtual address |
| acc_kind | input | 2 | Access kind (R3 encoding) |
| size_off | input | 6 | Region size offset |
| granule | input | 2 | Granule code (R6 encoding) |
| top_ign | input | 1 | Ignore top byte in range check |
| top_ign_data_only | input | 1 | Top-byte masking for non-fetch accesses only |
| tag_nib_ext | input | 1 | Treat bits 59:56 as zero |
| wide_mode | input | 1 | 52-bit mode, lowers the minimum offset to 12 |
| unchk_en | input | 1 | Unchecked-tag enable |
| pa_code | input | 3 | Physical size code |
| out_valid | output | 1 | Result valid |
| l0_fault | output | 1 | Level-0 translation fault |
| start_lvl | output | 3 | Initial lookup level, signed |
| oa_bits | output | 6 | Output address width in bits |
| tag_unchecked | output | 1 | Access is tag-unchecked |

## Verification
The assertions assume that `in_valid` is held low during reset, so that the first comparison with the previous cycle after reset sees a quiet input. They also assume the control fields are known whenever `in_valid` is high. The bench changes inputs only on the falling edge and keeps `in_valid` low while reset is active. The random size offsets are weighted toward the legal band, and the random addresses are shifted right by a random amount, so that results near the fault boundary occur often. Occasional random top bytes exercise the masking modes.

// File: rtl/va_range_check.sv
module va_range_check #(
  parameter int unsigned MIN_OFF_STD  = 16,
  parameter int unsigned MIN_OFF_WIDE = 12,
  parameter int unsigned MAX_OFF      = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] vaddr,
  input  logic [1:0]  acc_kind,
  input  logic [5:0]  size_off,
  input  logic [1:0]  granule,
  input  logic        top_ign,
  input  logic        top_ign_data_only,
  input  logic        tag_nib_ext,
  input  logic        wide_mode,
  input  logic        unchk_en,
  input  logic [2:0]  pa_code,
  output logic        out_valid,
  output logic        l0_fault,
  output logic [2:0]  start_lvl,
  output logic [5:0]  oa_bits,
  output logic        tag_unchecked
);

  localparam logic [1:0] ACC_FETCH = 2'b00;
  localparam logic [1:0] GR_64K    = 2'b01;
  localparam logic [1:0] GR_16K    = 2'b10;
  localparam logic [5:0] MIN_STD   = 6'(MIN_OFF_STD);
  localparam logic [5:0] MIN_WIDE  = 6'(MIN_OFF_WIDE);
  localparam logic [5:0] MAX_LEGAL = 6'(MAX_OFF);

  logic        mask_top;
  logic [63:0] chk_addr;
  logic [63:0] hi_mask;
  logic [5:0]  min_off;
  logic        off_bad;
  logic        fault_d;
  logic [2:0]  lvl_d;
  logic [5:0]  oa_d;
  logic        unchk_d;
  int          page_w;
  int          stride_w;
  int          res_bits;
  int          lv_cnt;

  assign mask_top = top_ign & ~(top_ign_data_only & (acc_kind == ACC_FETCH));
  assign chk_addr = {mask_top ? 4'h0 : vaddr[63:60],
                     (mask_top | tag_nib_ext) ? 4'h0 : vaddr[59:56],
                     vaddr[55:0]};
  assign hi_mask  = ~({64{1'b1}} >> size_off);
  assign min_off  = wide_mode ? MIN_WIDE : MIN_STD;
  assign off_bad  = (size_off < min_off) || (size_off > MAX_LEGAL);
  assign fault_d  = off_bad | (|(chk_addr & hi_mask));
  assign unchk_d  = unchk_en & (vaddr[59:56] == 4'h0);

  always_comb begin
    case (granule)
      GR_64K:  begin page_w = 16; stride_w = 13; end
      GR_16K:  begin page_w = 14; stride_w = 11; end
      default: begin page_w = 12; stride_w = 9;  end
    endcase
    res_bits = 64 - int'(size_off) - page_w;
    lv_cnt   = 1;
    for (int k = 1; k <= 4; k++) begin
      if (res_bits > k * stride_w) lv_cnt = lv_cnt + 1;
    end
    lvl_d = fault_d ? 3'd0 : 3'(4 - lv_cnt);
  end

  always_comb begin
    case (pa_code)
      3'd0:    oa_d = 6'd32;
      3'd1:    oa_d = 6'd36;
      3'd2:    oa_d = 6'd40;
      3'd3:    oa_d = 6'd42;
      3'd4:    oa_d = 6'd44;
      3'd5:    oa_d = 6'd48;
      3'd6:    oa_d = 6'd52;
      default: oa_d = 6'd56;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      l0_fault      <= 1'b0;
      start_lvl     <= 3'd0;
      oa_bits       <= 6'd0;
      tag_unchecked <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        l0_fault      <= fault_d;
        start_lvl     <= lvl_d;
        oa_bits       <= oa_d;
        tag_unchecked <= unchk_d;
      end
    end
  end

endmodule

// File: rtl/va_range_check_sva.sv
module va_range_check_sva #(
  parameter int unsigned MIN_OFF_WIDE = 12,
  parameter int unsigned MAX_OFF      = 48
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [5:0]  size_off,
  input logic [1:0]  granule,
  input logic        unchk_en,
  input logic        out_valid,
  input logic        l0_fault,
  input logic [2:0]  start_lvl,
  input logic [5:0]  oa_bits,
  input logic        tag_unchecked
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  a_r5_below_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_off < 6'(MIN_OFF_WIDE)) |=> l0_fault);

  a_r5_above_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_off > 6'(MAX_OFF)) |=> l0_fault);

  a_r6_level_span: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (start_lvl inside {3'b111, 3'd0, 3'd1, 3'd2, 3'd3}));

  a_r6_minus_one_small_granule: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && start_lvl == 3'b111) |-> ($past(granule) != 2'b01 && $past(granule) != 2'b10));

  a_r6_fault_level_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && l0_fault) |-> start_lvl == 3'd0);

  a_r7_oa_span: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (oa_bits >= 6'd32 && oa_bits <= 6'd56 && !oa_bits[0]));

  a_r8_unchecked_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !unchk_en) |=> !tag_unchecked);

endmodule

bind va_range_check va_range_check_sva #(
  .MIN_OFF_WIDE(MIN_OFF_WIDE),
  .MAX_OFF(MAX_OFF)
) u_sva (
  .clk(clk),
  .rst_n(rst_n),
  .in_valid(in_valid),
  .size_off(size_off),
  .granule(granule),
  .unchk_en(unchk_en),
  .out_valid(out_valid),
  .l0_fault(l0_fault),
  .start_lvl(start_lvl),
  .oa_bits(oa_bits),
  .tag_unchecked(tag_unchecked)
);

// File: tb/va_range_check_tb.sv
`timescale 1ns/1ps
module va_range_check_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] vaddr = '0;
  logic [1:0]  acc_kind = '0;
  logic [5:0]  size_off = '0;
  logic [1:0]  granule = '0;
  logic        top_ign = 1'b0;
  logic        top_ign_data_only = 1'b0;
  logic        tag_nib_ext = 1'b0;
  logic        wide_mode = 1'b0;
  logic        unchk_en = 1'b0;
  logic [2:0]  pa_code = '0;
  logic        out_valid;
  logic        l0_fault;
  logic [2:0]  start_lvl;
  logic [5:0]  oa_bits;
  logic        tag_unchecked;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  va_range_check u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vaddr(vaddr),
    .acc_kind(acc_kind), .size_off(size_off), .granule(granule),
    .top_ign(top_ign), .top_ign_data_only(top_ign_data_only),
    .tag_nib_ext(tag_nib_ext), .wide_mode(wide_mode), .unchk_en(unchk_en),
    .pa_code(pa_code), .out_valid(out_valid), .l0_fault(l0_fault),
    .start_lvl(start_lvl), .oa_bits(oa_bits), .tag_unchecked(tag_unchecked)
  );

  function automatic bit ref_fault();
    int so = int'(size_off);
    int lo = wide_mode ? 12 : 16;
    bit drop_top = top_ign && !(top_ign_data_only && acc_kind == 2'b00);
    if (so < lo || so > 48) return 1'b1;
    for (int i = 64 - so; i < 64; i++) begin
      if (i >= 56 && drop_top) continue;
      if (i >= 56 && i <= 59 && tag_nib_ext) continue;
      if (vaddr[i]) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic [2:0] ref_lvl(bit f);
    int p, s, b, l;
    if (f) return 3'd0;
    case (granule)
      2'b01: begin p = 16; s = 13; end
      2'b10: begin p = 14; s = 11; end
      default: begin p = 12; s = 9; end
    endcase
    b = 64 - int'(size_off) - p;
    l = (b + s - 1) / s;
    if (l < 1) l = 1;
    return 3'(4 - l);
  endfunction

  function automatic logic [5:0] ref_oa();
    int t [8] = '{32, 36, 40, 42, 44, 48, 52, 56};
    return 6'(t[pa_code]);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic run_one();
    bit ef;
    logic [2:0] el;
    logic [5:0] eo;
    bit eu;
    in_valid = 1'b1;
    ef = ref_fault();
    el = ref_lvl(ef);
    eo = ref_oa();
    eu = unchk_en && vaddr[59:56] == 4'h0;
    @(negedge clk);
    chk(out_valid == 1'b1, "R1", "out_valid", out_valid, 1);
    chk(l0_fault == ef, "R2", "l0_fault", l0_fault, ef);
    chk(start_lvl == el, "R6", "start_lvl", start_lvl, el);
    chk(oa_bits == eo, "R7", "oa_bits", oa_bits, eo);
    chk(tag_unchecked == eu, "R8", "tag_unchecked", tag_unchecked, eu);
  endtask

  task automatic setup(logic [63:0] a, logic [1:0] k, logic [5:0] so, logic [1:0] g,
                       bit ti, bit tdo, bit ex, bit w, bit ue);
    vaddr = a; acc_kind = k; size_off = so; granule = g; top_ign = ti;
    top_ign_data_only = tdo; tag_nib_ext = ex; wide_mode = w; unchk_en = ue;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && l0_fault == 0 && start_lvl == 0 && oa_bits == 0 && tag_unchecked == 0,
        "R1", "reset outputs", {out_valid, l0_fault, start_lvl, oa_bits, tag_unchecked}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: 4KB, offset 16, bit 48 set faults; bit 47 does not
    setup(64'h0001_0000_0000_0000, 2'b01, 6'd16, 2'b00, 0, 0, 0, 0, 0); run_one();
    setup(64'h0000_8000_0000_0000, 2'b01, 6'd16, 2'b00, 0, 0, 0, 0, 0); run_one();
    // R3: top byte masked for data, not for fetch with data-only qualifier
    setup(64'hA500_0000_0000_1000, 2'b01, 6'd16, 2'b00, 1, 1, 0, 0, 0); run_one();
    chk(l0_fault == 0, "R3", "data top-byte masked", l0_fault, 0);
    setup(64'hA500_0000_0000_1000, 2'b00, 6'd16, 2'b00, 1, 1, 0, 0, 0); run_one();
    chk(l0_fault == 1, "R3", "fetch top-byte kept", l0_fault, 1);
    setup(64'hA500_0000_0000_1000, 2'b10, 6'd16, 2'b00, 1, 1, 0, 0, 0); run_one();
    chk(l0_fault == 0, "R3", "maintenance masked", l0_fault, 0);
    // R4: tag nibble masked, upper nibble still checked
    setup(64'h0F00_0000_0000_0000, 2'b01, 6'd16, 2'b00, 0, 0, 1, 0, 0); run_one();
    chk(l0_fault == 0, "R4", "nibble masked", l0_fault, 0);
    setup(64'h1000_0000_0000_0000, 2'b01, 6'd16, 2'b00, 0, 0, 1, 0, 0); run_one();
    chk(l0_fault == 1, "R4", "upper nibble kept", l0_fault, 1);
    // R5: offset floor and ceiling
    setup(64'h0, 2'b01, 6'd12, 2'b00, 0, 0, 0, 0, 0); run_one();
    chk(l0_fault == 1, "R5", "offset 12 narrow", l0_fault, 1);
    setup(64'h0, 2'b01, 6'd12, 2'b00, 0, 0, 0, 1, 0); run_one();
    chk(l0_fault == 0 && start_lvl == 3'b111, "R5", "offset 12 wide", {l0_fault, start_lvl}, 7);
    setup(64'h0, 2'b01, 6'd49, 2'b00, 0, 0, 0, 1, 0); run_one();
    chk(l0_fault == 1, "R5", "offset 49", l0_fault, 1);
    // R6: 16KB boundary at 17, 64KB at 48, reserved granule as 4KB
    setup(64'h0, 2'b01, 6'd16, 2'b10, 0, 0, 0, 1, 0); run_one();
    chk(start_lvl == 3'd0, "R6", "16KB off 16", start_lvl, 0);
    setup(64'h0, 2'b01, 6'd17, 2'b10, 0, 0, 0, 1, 0); run_one();
    chk(start_lvl == 3'd1, "R6", "16KB off 17", start_lvl, 1);
    setup(64'h0, 2'b01, 6'd48, 2'b01, 0, 0, 0, 0, 0); run_one();
    chk(start_lvl == 3'd3, "R6", "64KB off 48", start_lvl, 3);
    setup(64'h0, 2'b01, 6'd25, 2'b11, 0, 0, 0, 0, 0); run_one();
    chk(start_lvl == 3'd1, "R6", "reserved granule", start_lvl, 1);
    // R7: every size code
    for (int c = 0; c < 8; c++) begin
      pa_code = 3'(c);
      run_one();
    end
    // R8: unchecked flag with masking on
    setup(64'hF000_0000_0000_0000, 2'b01, 6'd16, 2'b00, 1, 0, 0, 0, 1); run_one();
    chk(tag_unchecked == 1, "R8", "nibble zero", tag_unchecked, 1);
    setup(64'h0100_0000_0000_0000, 2'b01, 6'd16, 2'b00, 1, 0, 0, 0, 1); run_one();
    chk(tag_unchecked == 0, "R8", "nibble nonzero", tag_unchecked, 0);
    // R1: idle cycle
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 0, "R1", "idle", out_valid, 0);

    for (int n = 0; n < 4000; n++) begin
      logic [63:0] a;
      a = {$urandom, $urandom} >> ($urandom % 64);
      if ($urandom % 4 == 0) a[63:56] = 8'($urandom);
      acc_kind = 2'($urandom);
      size_off = ($urandom % 8 == 0) ? 6'($urandom) : 6'(10 + $urandom % 41);
      granule = 2'($urandom);
      top_ign = 1'($urandom);
      top_ign_data_only = 1'($urandom);
      tag_nib_ext = 1'($urandom);
      wide_mode = 1'($urandom);
      unchk_en = 1'($urandom);
      pa_code = 3'($urandom);
      vaddr = a;
      run_one();
      if ($urandom % 16 == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 0, "R1", "random idle", out_valid, 0);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule